// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Phase-to-Amplitude Converter

This block turns an unsigned phase word into signed sine and cosine samples for a direct digital synthesizer. The phase arrives on an AXI4-Stream slave port. Results leave on three AXI4-Stream master ports: one carries both values packed into a single word, one carries sine only and one carries cosine only. The phase accumulator and the tuning logic are not part of this block. They sit upstream and feed it one phase word per beat.

Only the first quarter period of the sine is held in a ROM. Its contents are computed by a constant function while the design elaborates. The top two phase bits pick the quadrant. The table index is mirrored in the odd quadrants and the sign is flipped in the upper half. The cosine reads the same ROM through a second port, at the phase advanced by a quarter turn. When the Taylor option is on, the ROM holds fewer points than the phase can resolve. The leftover low phase bits then form a residual angle, and each output is corrected along its slope from the table point just below the phase. The slope of the sine is the cosine already read from the ROM, and the slope of the cosine is the negated sine. Each output can be negated on its own by a parameter.

The three output ports move as one bundle. A result leaves in the cycle where every enabled output ready is high. Otherwise the whole pipeline holds, and the input ready drops.

Top module: `qwave_sincos`

## Requirements
- R1: With Taylor correction on (12-bit phase, 8-bit table address, 16-bit output), the sine output is within ±2 LSB of round(32767·sin(2π·p/4096)) for phase word p.
- R2: With Taylor correction off, the table address width becomes phase width minus 2. The sine output is then within ±1 LSB of the same rounded ideal value, before any inversion.
- R3: The cosine output follows round(32767·cos(2π·p/4096)) with the same tolerance as the sine of the same configuration.
- R4: The combined output word carries the cosine in bits [2·OUT_W-1:OUT_W] and the sine in bits [OUT_W-1:0]. Both fields equal the values on the separate sine and cosine ports.
- R5: When a sine-invert or cosine-invert parameter is set, that output is the two's-complement negation of the value it would otherwise have. The other output is unaffected.
- R6: With all output readies held high, a phase accepted on a rising edge produces a valid output that is visible after the fourth rising edge, counting the accepting edge as the first.
- R7: The input ready equals the AND of the enabled output readies. While a valid result is held back, the output valid and data stay stable. No beat is lost or duplicated.
- R8: No output ever exceeds the range ±(2^(OUT_W-1)-1), including after Taylor correction near the peaks.
- R9: While the active-low synchronous reset is sampled low, all output valids are cleared on the next edge.
- R10: At phase words that are exact multiples of a quarter turn (0, 1024, 2048, 3072), the outputs are exact: 0, +32767, 0 and -32767 for sine, with the cosine advanced by a quarter turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_axis_phase_tdata | input | PHASE_W | Unsigned phase word |
| s_axis_phase_tvalid | input | 1 | Phase beat valid |
| s_axis_phase_tready | output | 1 | Pipeline can accept a phase |
| m_axis_both_tdata | output | 2*OUT_W | Cosine in the upper field, sine in the lower field |
| m_axis_both_tvalid | output | 1 | Combined result valid |
| m_axis_both_tready | input | 1 | Combined consumer ready |
| m_axis_sin_tdata | output | OUT_W | Signed sine sample |
| m_axis_sin_tvalid | output | 1 | Sine result valid |
| m_axis_sin_tready | input | 1 | Sine consumer ready |
| m_axis_cos_tdata | output | OUT_W | Signed cosine sample (zero when cosine is disabled) |
| m_axis_cos_tvalid | output | 1 | Cosine result valid (low when cosine is disabled) |
| m_axis_cos_tready | input | 1 | Cosine consumer ready (ignored when cosine is disabled) |

## Verification
Some properties are checked on every cycle. The outputs stay inside the symmetric range after correction. A held result keeps its valid and data frozen while any ready is low. Reset clears the valids. An accepted phase shows up as a valid result four edges later when nothing stalls. Numerical accuracy cannot be stated as a cycle property and is left to the bench scenarios. These cover the error against a real-valued sine and cosine for both the corrected and uncorrected table, exact values at the quadrant boundaries, independent inversion, field placement in the packed word, and the ordering of beats under random back-pressure.

// File: rtl/qwave_pkg.sv
package qwave_pkg;

   localparam real PI_R = 3.14159265358979323846;

   // Quarter-wave magnitude for table entry idx of a table with 2**aw
   // steps per quarter turn, scaled to 2**(ow-1)-1.
   function automatic int sine_mag(input int idx, input int aw, input int ow);
      real x;
      real term;
      real acc;
      real amp;
      int  val;
      x    = (real'(idx) * PI_R) / (2.0 * (2.0 ** aw));
      term = x;
      acc  = x;
      for (int k = 1; k < 12; k++) begin
         term = -term * x * x / real'((2 * k) * (2 * k + 1));
         acc  = acc + term;
      end
      amp = (2.0 ** (ow - 1)) - 1.0;
      val = $rtoi(acc * amp + 0.5);
      if (val > $rtoi(amp)) val = $rtoi(amp);
      if (val < 0) val = 0;
      return val;
   endfunction

   // 2*pi as a fixed-point constant with frac_bits fractional bits.
   function automatic int tau_fixed(input int frac_bits);
      return $rtoi(2.0 * PI_R * (2.0 ** frac_bits) + 0.5);
   endfunction

endpackage

// File: rtl/qwave_rom.sv
module qwave_rom #(
   parameter int TAB_AW = 8,
   parameter int OUT_W  = 16
) (
   input  logic              clk,
   input  logic              en,
   input  logic [TAB_AW:0]   idx_a,
   input  logic [TAB_AW:0]   idx_b,
   output logic [OUT_W-2:0]  mag_a,
   output logic [OUT_W-2:0]  mag_b
);

   // One extra entry holds the exact peak so mirrored reads never wrap.
   localparam int DEPTH = (1 << TAB_AW) + 1;

   logic [OUT_W-2:0] tab [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam int VAL = qwave_pkg::sine_mag(i, TAB_AW, OUT_W);
      assign tab[i] = (OUT_W-1)'(VAL);
   end

   // Two read ports: one for the sine phase, one for the quarter-advanced phase.
   always_ff @(posedge clk) begin
      if (en) begin
         mag_a <= tab[idx_a];
         mag_b <= tab[idx_b];
      end
   end

endmodule

// File: rtl/qwave_correct.sv
module qwave_correct #(
   parameter int PHASE_W = 12,
   parameter int OUT_W   = 16,
   parameter int FRAC_W  = 2,
   parameter int DW      = 2,
   parameter bit SIN_NEG = 1'b0,
   parameter bit COS_NEG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              v_in,
   input  logic [OUT_W-2:0]  mag_s,
   input  logic [OUT_W-2:0]  mag_c,
   input  logic              neg_s,
   input  logic              neg_c,
   input  logic [DW-1:0]     frac,
   output logic              v_out,
   output logic [OUT_W-1:0]  sin_o,
   output logic [OUT_W-1:0]  cos_o
);

   localparam int SUM_W = OUT_W + 2;
   localparam logic signed [SUM_W-1:0] AMP_S = SUM_W'((1 << (OUT_W - 1)) - 1);

   logic signed [SUM_W-1:0] ms, mc, base_s, base_c;
   logic signed [SUM_W-1:0] b3_s, b3_c;
   logic signed [SUM_W-1:0] corr_s, corr_c;
   logic signed [SUM_W-1:0] sum_s, sum_c, sat_s, sat_c, fin_s, fin_c;
   logic                    v3;

   // Quadrant sign applied to the table magnitudes.
   always_comb begin
      ms     = SUM_W'(mag_s);
      mc     = SUM_W'(mag_c);
      base_s = neg_s ? -ms : ms;
      base_c = neg_c ? -mc : mc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v3 <= 1'b0;
      end else if (en) begin
         v3 <= v_in;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         b3_s <= base_s;
         b3_c <= base_c;
      end
   end

   if (FRAC_W > 0) begin : g_taylor
      localparam int KF     = 18;
      localparam int KW     = KF + 4;
      localparam int PROD_W = SUM_W + DW + 1 + KW;
      localparam int SH     = PHASE_W + KF;
      localparam logic signed [PROD_W-1:0] K_TAU = PROD_W'(qwave_pkg::tau_fixed(KF));
      localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) <<< (SH - 1);

      logic signed [PROD_W-1:0] fx, p3_s, p3_c, r_s, r_c;

      always_comb fx = PROD_W'(frac);

      // Slope terms: d(sin)=cos, d(cos)=-sin, both from the same table reads.
      always_ff @(posedge clk) begin
         if (en) begin
            p3_s <= PROD_W'(base_c) * fx * K_TAU;
            p3_c <= PROD_W'(base_s) * fx * K_TAU;
         end
      end

      always_comb begin
         r_s    = (p3_s + HALF) >>> SH;
         r_c    = (p3_c + HALF) >>> SH;
         corr_s = SUM_W'(r_s);
         corr_c = -SUM_W'(r_c);
      end
   end else begin : g_plain
      assign corr_s = '0;
      assign corr_c = '0;
   end

   always_comb begin
      sum_s = b3_s + corr_s;
      sum_c = b3_c + corr_c;
      sat_s = (sum_s > AMP_S) ? AMP_S : ((sum_s < -AMP_S) ? -AMP_S : sum_s);
      sat_c = (sum_c > AMP_S) ? AMP_S : ((sum_c < -AMP_S) ? -AMP_S : sum_c);
      fin_s = SIN_NEG ? -sat_s : sat_s;
      fin_c = COS_NEG ? -sat_c : sat_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_out <= 1'b0;
      end else if (en) begin
         v_out <= v3;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         sin_o <= fin_s[OUT_W-1:0];
         cos_o <= fin_c[OUT_W-1:0];
      end
   end

   // R8: results stay inside the symmetric amplitude range
   p_in_range_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      v_out |-> ($signed(sin_o) <= $signed(AMP_S[OUT_W-1:0]))
             && ($signed(sin_o) >= -$signed(AMP_S[OUT_W-1:0]))
             && ($signed(cos_o) <= $signed(AMP_S[OUT_W-1:0]))
             && ($signed(cos_o) >= -$signed(AMP_S[OUT_W-1:0])));

   // R7: a held result keeps its valid and data while stalled
   p_hold_stall_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (v_out && !en) |=> (v_out && $stable(sin_o) && $stable(cos_o)));

endmodule

// File: rtl/qwave_sincos.sv
module qwave_sincos #(
   parameter int PHASE_W   = 12,
   parameter int OUT_W     = 16,
   parameter bit TAYLOR_EN = 1'b1,
   parameter int ADDR_W    = 8,
   parameter bit COS_EN    = 1'b1,
   parameter bit SIN_NEG   = 1'b0,
   parameter bit COS_NEG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PHASE_W-1:0]   s_axis_phase_tdata,
   input  logic                 s_axis_phase_tvalid,
   output logic                 s_axis_phase_tready,
   output logic [2*OUT_W-1:0]   m_axis_both_tdata,
   output logic                 m_axis_both_tvalid,
   input  logic                 m_axis_both_tready,
   output logic [OUT_W-1:0]     m_axis_sin_tdata,
   output logic                 m_axis_sin_tvalid,
   input  logic                 m_axis_sin_tready,
   output logic [OUT_W-1:0]     m_axis_cos_tdata,
   output logic                 m_axis_cos_tvalid,
   input  logic                 m_axis_cos_tready
);

   localparam int TAB_AW = TAYLOR_EN ? ADDR_W : (PHASE_W - 2);
   localparam int FRAC_W = PHASE_W - 2 - TAB_AW;
   localparam int DW     = (FRAC_W > 0) ? FRAC_W : 1;
   localparam int CUT_W  = TAB_AW + 2;
   localparam logic [TAB_AW:0]  TOP_IDX = (TAB_AW+1)'(1) << TAB_AW;
   localparam logic [CUT_W-1:0] QUARTER = CUT_W'(1) << TAB_AW;

   // Elaboration-time parameter checks
   if (PHASE_W < 4 || PHASE_W > 32) begin : g_bad_phase
      $error("qwave_sincos: PHASE_W must lie in 4..32");
   end
   if (OUT_W < 4 || OUT_W > 24) begin : g_bad_out
      $error("qwave_sincos: OUT_W must lie in 4..24");
   end
   if (TAYLOR_EN && (ADDR_W < 2 || ADDR_W > PHASE_W - 2)) begin : g_bad_addr
      $error("qwave_sincos: ADDR_W must lie in 2..PHASE_W-2 with correction on");
   end

   logic cos_rdy, adv, take;
   assign cos_rdy = COS_EN ? m_axis_cos_tready : 1'b1;
   assign adv     = m_axis_both_tready & m_axis_sin_tready & cos_rdy;
   assign take    = s_axis_phase_tvalid & adv;
   assign s_axis_phase_tready = adv;

   // Stage 1: capture phase
   logic               v1;
   logic [PHASE_W-1:0] ph1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;
      end else if (adv) begin
         v1 <= s_axis_phase_tvalid;
      end
   end

   always_ff @(posedge clk) begin
      if (adv) ph1 <= s_axis_phase_tdata;
   end

   // Quadrant folding for the sine phase and the quarter-advanced phase
   logic [CUT_W-1:0] cut_s, cut_c;
   logic [TAB_AW:0]  idx_s, idx_c;
   logic [DW-1:0]    frac1;

   always_comb begin
      cut_s = ph1[PHASE_W-1 -: CUT_W];
      cut_c = cut_s + QUARTER;
      idx_s = cut_s[CUT_W-2] ? (TOP_IDX - {1'b0, cut_s[TAB_AW-1:0]}) : {1'b0, cut_s[TAB_AW-1:0]};
      idx_c = cut_c[CUT_W-2] ? (TOP_IDX - {1'b0, cut_c[TAB_AW-1:0]}) : {1'b0, cut_c[TAB_AW-1:0]};
   end

   if (FRAC_W > 0) begin : g_frac
      assign frac1 = ph1[DW-1:0];
   end else begin : g_nofrac
      assign frac1 = '0;
   end

   // Stage 2: table read plus sideband
   logic             v2, neg_s2, neg_c2;
   logic [DW-1:0]    frac2;
   logic [OUT_W-2:0] mag_s2, mag_c2;

   qwave_rom #(
      .TAB_AW (TAB_AW),
      .OUT_W  (OUT_W)
   ) u_rom (
      .clk   (clk),
      .en    (adv),
      .idx_a (idx_s),
      .idx_b (idx_c),
      .mag_a (mag_s2),
      .mag_b (mag_c2)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2 <= 1'b0;
      end else if (adv) begin
         v2 <= v1;
      end
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         neg_s2 <= cut_s[CUT_W-1];
         neg_c2 <= cut_c[CUT_W-1];
         frac2  <= frac1;
      end
   end

   // Stages 3 and 4: sign, correction, saturation, inversion
   logic             v4;
   logic [OUT_W-1:0] sin4, cos4;

   qwave_correct #(
      .PHASE_W (PHASE_W),
      .OUT_W   (OUT_W),
      .FRAC_W  (FRAC_W),
      .DW      (DW),
      .SIN_NEG (SIN_NEG),
      .COS_NEG (COS_NEG)
   ) u_correct (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv),
      .v_in  (v2),
      .mag_s (mag_s2),
      .mag_c (mag_c2),
      .neg_s (neg_s2),
      .neg_c (neg_c2),
      .frac  (frac2),
      .v_out (v4),
      .sin_o (sin4),
      .cos_o (cos4)
   );

   assign m_axis_sin_tdata   = sin4;
   assign m_axis_sin_tvalid  = v4;
   assign m_axis_both_tvalid = v4;

   if (COS_EN) begin : g_cos
      assign m_axis_cos_tdata  = cos4;
      assign m_axis_cos_tvalid = v4;
      assign m_axis_both_tdata = {cos4, sin4};
   end else begin : g_nocos
      assign m_axis_cos_tdata  = '0;
      assign m_axis_cos_tvalid = 1'b0;
      assign m_axis_both_tdata = {{OUT_W{1'b0}}, sin4};
   end

   // R9: reset clears the output valids on the next edge
   p_reset_clears_r9 : assert property (@(posedge clk)
      !rst_n |=> (!m_axis_sin_tvalid && !m_axis_both_tvalid));

   // R6: an accepted phase is valid at the output four edges later when nothing stalls
   p_latency_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(take, 4) && $past(rst_n, 4) && $past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1)
       && $past(adv, 3) && $past(adv, 2) && $past(adv, 1)) |-> m_axis_sin_tvalid);

endmodule

// File: tb/qwave_sincos_bench.sv
`timescale 1ns/1ps
module qwave_sincos_bench;

   localparam int PW  = 12;
   localparam int OW  = 16;
   localparam int AMP = 32767;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] s_phase = '0;
   logic          s_valid = 1'b0;
   logic          rdy_both = 1'b1, rdy_sin = 1'b1, rdy_cos = 1'b1;

   logic [2*OW-1:0] both_a, both_b;
   logic [OW-1:0]   sin_a, sin_b, cos_a, cos_b;
   logic            s_rdy_a, s_rdy_b;
   logic            vb_a, vs_a, vc_a, vb_b, vs_b, vc_b;

   int n_cmp = 0;
   int n_bad = 0;
   logic [PW-1:0] exp_q [$];

   always #2 clk = ~clk;

   qwave_sincos #(.PHASE_W(PW), .OUT_W(OW), .TAYLOR_EN(1'b1), .ADDR_W(8),
                  .COS_EN(1'b1), .SIN_NEG(1'b0), .COS_NEG(1'b0)) u_qwave_sincos (
      .clk(clk), .rst_n(rst_n),
      .s_axis_phase_tdata(s_phase), .s_axis_phase_tvalid(s_valid), .s_axis_phase_tready(s_rdy_a),
      .m_axis_both_tdata(both_a), .m_axis_both_tvalid(vb_a), .m_axis_both_tready(rdy_both),
      .m_axis_sin_tdata(sin_a), .m_axis_sin_tvalid(vs_a), .m_axis_sin_tready(rdy_sin),
      .m_axis_cos_tdata(cos_a), .m_axis_cos_tvalid(vc_a), .m_axis_cos_tready(rdy_cos));

   qwave_sincos #(.PHASE_W(PW), .OUT_W(OW), .TAYLOR_EN(1'b0), .ADDR_W(8),
                  .COS_EN(1'b1), .SIN_NEG(1'b1), .COS_NEG(1'b1)) u_qwave_sincos_plain (
      .clk(clk), .rst_n(rst_n),
      .s_axis_phase_tdata(s_phase), .s_axis_phase_tvalid(s_valid), .s_axis_phase_tready(s_rdy_b),
      .m_axis_both_tdata(both_b), .m_axis_both_tvalid(vb_b), .m_axis_both_tready(rdy_both),
      .m_axis_sin_tdata(sin_b), .m_axis_sin_tvalid(vs_b), .m_axis_sin_tready(rdy_sin),
      .m_axis_cos_tdata(cos_b), .m_axis_cos_tvalid(vc_b), .m_axis_cos_tready(rdy_cos));

   function automatic int ideal(input logic [PW-1:0] p, input bit want_cos);
      real ang;
      real v;
      ang = 2.0 * 3.14159265358979323846 * real'(p) / 4096.0;
      v   = want_cos ? $cos(ang) : $sin(ang);
      return $rtoi($floor(v * real'(AMP) + 0.5));
   endfunction

   task automatic check_near(input string tag, input int got, input int exp, input int tol,
                             input logic [PW-1:0] p);
      int diff;
      n_cmp++;
      diff = got - exp;
      if (diff < 0) diff = -diff;
      if (diff > tol) begin
         n_bad++;
         $display("FAIL %s phase=%0d: got %0d expected %0d (tol %0d)", tag, p, got, exp, tol);
      end
   endtask

   task automatic check_bit(input string tag, input logic got, input logic exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic check_beat(input logic [PW-1:0] p);
      int es, ec, ta, tb;
      bit corner;
      corner = (p[PW-3:0] == '0);
      es = ideal(p, 1'b0);
      ec = ideal(p, 1'b1);
      ta = corner ? 0 : 2;
      tb = corner ? 0 : 1;
      if (corner) begin
         check_near("R10 sine corner", int'($signed(sin_a)), es, 0, p);
         check_near("R10 cosine corner", int'($signed(cos_a)), ec, 0, p);
      end
      check_near("R1 sine corrected", int'($signed(sin_a)), es, ta, p);
      check_near("R3 cosine corrected", int'($signed(cos_a)), ec, ta, p);
      check_near("R2 R5 sine plain inverted", int'($signed(sin_b)), -es, tb, p);
      check_near("R3 R5 cosine plain inverted", int'($signed(cos_b)), -ec, tb, p);
      check_near("R4 packed sine field", int'($signed(both_a[OW-1:0])), int'($signed(sin_a)), 0, p);
      check_near("R4 packed cosine field", int'($signed(both_a[2*OW-1:OW])), int'($signed(cos_a)), 0, p);
      check_near("R4 packed plain word", int'($signed(both_b[2*OW-1:OW])), int'($signed(cos_b)), 0, p);
      check_near("R8 range sine", (int'($signed(sin_a)) > AMP || int'($signed(sin_a)) < -AMP) ? 1 : 0, 0, 0, p);
      check_near("R8 range cosine", (int'($signed(cos_a)) > AMP || int'($signed(cos_a)) < -AMP) ? 1 : 0, 0, 0, p);
   endtask

   // Evaluate the cycle before the next rising edge, then move to the next falling edge.
   task automatic tick();
      logic all_rdy;
      logic [PW-1:0] p;
      #1;
      all_rdy = rdy_both & rdy_sin & rdy_cos;
      check_bit("R7 input ready", s_rdy_a, all_rdy);
      if (rst_n && vs_a && all_rdy) begin
         if (exp_q.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R7 extra beat: got a result, expected none");
         end else begin
            p = exp_q.pop_front();
            check_beat(p);
         end
      end
      if (rst_n && s_valid && s_rdy_a) exp_q.push_back(s_phase);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [OW-1:0] snap_s, snap_c;
      @(negedge clk);
      repeat (3) tick();
      // R9: reset state
      check_bit("R9 reset sine valid", vs_a, 1'b0);
      check_bit("R9 reset packed valid", vb_b, 1'b0);
      rst_n = 1'b1;
      tick();

      // R6: latency with readies high
      s_phase = 12'd300;
      s_valid = 1'b1;
      tick();
      s_valid = 1'b0;
      check_bit("R6 not yet valid +1", vs_a, 1'b0);
      tick();
      check_bit("R6 not yet valid +2", vs_a, 1'b0);
      tick();
      check_bit("R6 not yet valid +3", vs_a, 1'b0);
      tick();
      check_bit("R6 valid after fourth edge", vs_a, 1'b1);
      tick();

      // R10: quarter-turn corners
      for (int q = 0; q < 4; q++) begin
         s_phase = PW'(q * 1024);
         s_valid = 1'b1;
         tick();
      end
      s_valid = 1'b0;
      repeat (6) tick();

      // R7: stall with one ready low while results are in flight
      for (int k = 0; k < 6; k++) begin
         s_phase = PW'($urandom);
         s_valid = 1'b1;
         tick();
      end
      rdy_sin = 1'b0;
      snap_s = sin_a;
      snap_c = cos_b;
      for (int k = 0; k < 5; k++) begin
         tick();
         check_bit("R7 valid held", vs_a, 1'b1);
         check_near("R7 sine held", int'(sin_a), int'(snap_s), 0, s_phase);
         check_near("R7 cosine held", int'(cos_b), int'(snap_c), 0, s_phase);
      end
      rdy_sin = 1'b1;
      s_valid = 1'b0;
      repeat (8) tick();

      // Random phases and back-pressure
      for (int k = 0; k < 3000; k++) begin
         s_phase  = PW'($urandom);
         s_valid  = ($urandom % 4) != 0;
         rdy_both = ($urandom % 5) != 0;
         rdy_sin  = ($urandom % 5) != 0;
         rdy_cos  = ($urandom % 5) != 0;
         tick();
      end

      // R9: reset in the middle of traffic
      rst_n = 1'b0;
      s_valid = 1'b0;
      rdy_both = 1'b1;
      rdy_sin = 1'b1;
      rdy_cos = 1'b1;
      tick();
      tick();
      check_bit("R9 mid-run reset sine valid", vs_a, 1'b0);
      check_bit("R9 mid-run reset cosine valid", vc_b, 1'b0);
      exp_q.delete();
      rst_n = 1'b1;
      tick();

      // Short sweep after reset, then drain
      for (int k = 0; k < 256; k++) begin
         s_phase = PW'(k * 16 + 3);
         s_valid = 1'b1;
         tick();
      end
      s_valid = 1'b0;
      repeat (10) tick();
      // R7: nothing lost
      check_near("R7 all beats delivered", exp_q.size(), 0, 0, '0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule